// File: doc/BRIEF.md
# Tape Motion Start and Acceleration Delay Sequencer

This block starts tape motion on one of several transports that share a slave bus. It then times the acceleration interval before the read path may be used. A 3-bit select code names the transport. Only that transport, and only while it is on-line, reports its ready and settling status back through the block. A drive-set request is acted on only when the selected transport is on-line and has tape loaded. The block then releases the stop line, fires a one-cycle start pulse and raises a delay-load strobe. While the strobe is high, a 14-bit preset is loaded into the motion-delay counter.

After the strobe falls, the counter advances once per density clock tick. When it reaches 2^14 it freezes, acceleration ends and reading is enabled. The acceleration interval therefore lasts 2^14 minus the preset ticks, so a preset of zero gives the longest interval.

A stop request puts the block back into the stopped state and re-arms the counter. A rewind command starts motion without any acceleration timing. The block then returns to the stopped state, because the transport goes off-line.

Top module: `tmotion_seq`

## Requirements
- R1: After reset, stop_o is 1; start_pls_o, delay_load_o, accel_o and reading_o are 0; sel_code_o is 0 and mode_o is 0.
- R2: A qualified drive_set_i while stopped gives, from the next cycle: stop_o=0, start_pls_o=1 for exactly one cycle, and delay_load_o=1 for LOAD_CYC cycles (default 2). For non-rewind commands, accel_o=1 from that same cycle.
- R3: While stopped, sel_code_o takes the value of unit_sel_i one cycle later. sel_ready_o and sel_settle_o show the ready and settle bits of transport sel_code_o only while that transport's on-line bit is 1; otherwise they are 0.
- R4: The preset is loaded while delay_load_o is 1, and ticks during that window are not counted. After it, each cycle with tick_i=1 advances the counter by one.
- R5: After exactly 2^14 - preset counted ticks, the next cycle shows accel_o=0 and reading_o=1. Counting then stops, and reading_o stays 1 until a stop request.
- R6: drive_set_i is ignored when the selected transport is off-line or has no tape loaded: stop_o stays 1 and no start pulse is produced.
- R7: While motion is active (stop_o=0), changes on unit_sel_i do not change sel_code_o.
- R8: stop_req_i gives stop_o=1 with reading_o, accel_o and delay_load_o all 0 in the next cycle. It takes priority over drive_set_i, and a later start times a full fresh delay.
- R9: drive_set_i is ignored while motion is active: no new start pulse, and the delay count is not reloaded.
- R10: mode_o is latched at each start. It is 3 (rewind) when cmd_rewind_i=1, whatever cmd_write_i is; 2 (write) when only cmd_write_i=1; and 1 (move) otherwise. A rewind start never raises accel_o or reading_o, and stop_o returns to 1 after the delay-load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unit_sel_i | input | 3 | Requested transport number |
| online_vec_i | input | 8 | On-line bit of each transport |
| medium_vec_i | input | 8 | Tape-loaded bit of each transport |
| ready_vec_i | input | 8 | Ready bit of each transport |
| settle_vec_i | input | 8 | Settling-down bit of each transport |
| drive_set_i | input | 1 | Request to start motion |
| stop_req_i | input | 1 | Request to stop motion |
| cmd_write_i | input | 1 | Write command line |
| cmd_rewind_i | input | 1 | Rewind command line |
| tick_i | input | 1 | Density clock tick, one cycle wide |
| preset_i | input | 14 | Motion-delay preset |
| sel_code_o | output | 3 | Select code driven on the slave bus |
| sel_ready_o | output | 1 | Ready status of the connected transport |
| sel_settle_o | output | 1 | Settling status of the connected transport |
| stop_o | output | 1 | Stop line |
| start_pls_o | output | 1 | Start pulse |
| delay_load_o | output | 1 | Motion-delay load strobe |
| accel_o | output | 1 | Acceleration in progress |
| reading_o | output | 1 | Read path enabled |
| mode_o | output | 2 | Latched command kind |

## Verification
The delay count is tried with presets near the top of the range at one tick per cycle, with a middle preset at one tick every third cycle, and with the two extremes 0 and 16383. The tick-rate runs show that only ticks are counted and not clock cycles. The extremes expose off-by-one and wrap errors at the terminal count. The start requests vary the selected transport's on-line and loaded bits, which separates a correct status mux from one that reads the wrong transport. The command lines are tried with all three combinations, which tells the rewind path apart from the timed paths. Stop requests are placed in the middle of a count, so a counter that is not re-armed shows up as a short delay on the next run.

// File: rtl/tmotion_pkg.sv
package tmotion_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_MOVE   = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_REWIND = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_ACCEL = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;

  // Rewind wins over write; plain motion otherwise.
  function automatic mode_e classify_cmd(input logic wr, input logic rw);
    if (rw)      return MODE_REWIND;
    else if (wr) return MODE_WRITE;
    else         return MODE_MOVE;
  endfunction

  // Delay length in ticks for a preset of the given width.
  function automatic int unsigned delay_ticks(input int unsigned preset,
                                              input int unsigned width);
    return (32'd1 << width) - preset;
  endfunction

endpackage

// File: rtl/tmotion_select.sv
module tmotion_select #(
  parameter int NUM_UNITS = 8,
  parameter int SEL_W     = $clog2(NUM_UNITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hold_i,
  input  logic [SEL_W-1:0]     unit_sel_i,
  input  logic [NUM_UNITS-1:0] online_vec_i,
  input  logic [NUM_UNITS-1:0] medium_vec_i,
  input  logic [NUM_UNITS-1:0] ready_vec_i,
  input  logic [NUM_UNITS-1:0] settle_vec_i,
  output logic [SEL_W-1:0]     sel_code_o,
  output logic                 sel_online_o,
  output logic                 sel_loaded_o,
  output logic                 sel_ready_o,
  output logic                 sel_settle_o
);

  logic [SEL_W-1:0]     sel_q;
  logic [NUM_UNITS-1:0] connected;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (!hold_i) sel_q <= unit_sel_i;
  end

  // A transport joins the bus only on a code match while on-line.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign connected[u] = (sel_q == SEL_W'(u)) && online_vec_i[u];
  end

  assign sel_code_o   = sel_q;
  assign sel_online_o = |connected;
  assign sel_loaded_o = |(connected & medium_vec_i);
  assign sel_ready_o  = |(connected & ready_vec_i);
  assign sel_settle_o = |(connected & settle_vec_i);

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> $stable(sel_code_o)); // R7

endmodule

// File: rtl/tmotion_delay_cnt.sv
module tmotion_delay_cnt #(
  parameter int PRESET_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                load_i,
  input  logic                count_en_i,
  input  logic                tick_i,
  input  logic [PRESET_W-1:0] preset_i,
  output logic                last_tick_o
);

  localparam int CW = PRESET_W + 1;
  localparam logic [CW-1:0] LAST_VAL = {1'b0, {PRESET_W{1'b1}}};

  logic [CW-1:0] cnt_q;
  logic          at_term;
  logic          step;

  assign at_term     = cnt_q[PRESET_W];
  assign step        = count_en_i && tick_i && !at_term;
  assign last_tick_o = step && (cnt_q == LAST_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= {1'b0, preset_i};
    else if (step)    cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_term && !clear_i && !load_i |=> $stable(cnt_q)); // R5

  AST_CNT_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clear_i |=> !at_term && (cnt_q[PRESET_W-1:0] == $past(preset_i))); // R4

endmodule

// File: rtl/tmotion_ctrl.sv
module tmotion_ctrl
  import tmotion_pkg::*;
#(
  parameter int LOAD_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drive_set_i,
  input  logic       stop_req_i,
  input  logic       sel_online_i,
  input  logic       sel_loaded_i,
  input  logic       cmd_write_i,
  input  logic       cmd_rewind_i,
  input  logic       last_tick_i,
  output logic       stop_o,
  output logic       start_pls_o,
  output logic       delay_load_o,
  output logic       accel_o,
  output logic       reading_o,
  output logic       count_en_o,
  output logic       ctr_clear_o,
  output logic       hold_o,
  output logic [1:0] mode_o
);

  localparam int LW = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
  localparam logic [LW-1:0] LOAD_LAST = LW'(LOAD_CYC - 1);

  phase_e        phase_q, phase_d;
  mode_e         mode_q;
  logic [LW-1:0] load_cnt_q;

  logic qualified;
  logic start_ev;
  logic load_done;

  assign qualified = sel_online_i && sel_loaded_i;
  assign start_ev  = (phase_q == PH_IDLE) && drive_set_i && qualified && !stop_req_i;
  assign load_done = (phase_q == PH_LOAD) && (load_cnt_q == LOAD_LAST);

  always_comb begin
    phase_d = phase_q;
    if (stop_req_i) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (start_ev) phase_d = PH_LOAD;
        PH_LOAD:  if (load_done) phase_d = (mode_q == MODE_REWIND) ? PH_IDLE : PH_ACCEL;
        PH_ACCEL: if (last_tick_i) phase_d = PH_RUN;
        PH_RUN:   phase_d = PH_RUN;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      mode_q     <= MODE_NONE;
      load_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (start_ev) begin
        mode_q     <= classify_cmd(cmd_write_i, cmd_rewind_i);
        load_cnt_q <= '0;
      end else if (phase_q == PH_LOAD && !load_done) begin
        load_cnt_q <= load_cnt_q + LW'(1);
      end
    end
  end

  assign stop_o       = (phase_q == PH_IDLE);
  assign start_pls_o  = (phase_q == PH_LOAD) && (load_cnt_q == '0);
  assign delay_load_o = (phase_q == PH_LOAD);
  assign accel_o      = ((phase_q == PH_LOAD) && (mode_q != MODE_REWIND)) ||
                        (phase_q == PH_ACCEL);
  assign reading_o    = (phase_q == PH_RUN);
  assign count_en_o   = (phase_q == PH_ACCEL);
  assign ctr_clear_o  = (phase_q == PH_IDLE);
  assign hold_o       = (phase_q != PH_IDLE);
  assign mode_o       = mode_q;

  AST_START_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_pls_o) |-> $past(drive_set_i && qualified)); // R6

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pls_o |=> !start_pls_o); // R2

  AST_START_WITH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pls_o |-> delay_load_o && !stop_o); // R2

  AST_READ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reading_o |-> !accel_o && !stop_o && !delay_load_o); // R5

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i |=> stop_o && !reading_o && !accel_o); // R8

  AST_REWIND_NO_ACCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_REWIND) |-> !accel_o && !reading_o); // R10

endmodule

// File: rtl/tmotion_seq.sv
module tmotion_seq
  import tmotion_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int PRESET_W  = 14,
  parameter int LOAD_CYC  = 2,
  localparam int SEL_W    = $clog2(NUM_UNITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     unit_sel_i,
  input  logic [NUM_UNITS-1:0] online_vec_i,
  input  logic [NUM_UNITS-1:0] medium_vec_i,
  input  logic [NUM_UNITS-1:0] ready_vec_i,
  input  logic [NUM_UNITS-1:0] settle_vec_i,
  input  logic                 drive_set_i,
  input  logic                 stop_req_i,
  input  logic                 cmd_write_i,
  input  logic                 cmd_rewind_i,
  input  logic                 tick_i,
  input  logic [PRESET_W-1:0]  preset_i,
  output logic [SEL_W-1:0]     sel_code_o,
  output logic                 sel_ready_o,
  output logic                 sel_settle_o,
  output logic                 stop_o,
  output logic                 start_pls_o,
  output logic                 delay_load_o,
  output logic                 accel_o,
  output logic                 reading_o,
  output logic [1:0]           mode_o
);

  // Named internal events, visible to assertions.
  logic sel_online;
  logic sel_loaded;
  logic hold;
  logic last_tick;
  logic count_en;
  logic ctr_clear;

  tmotion_select #(
    .NUM_UNITS(NUM_UNITS),
    .SEL_W    (SEL_W)
  ) select_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold),
    .unit_sel_i  (unit_sel_i),
    .online_vec_i(online_vec_i),
    .medium_vec_i(medium_vec_i),
    .ready_vec_i (ready_vec_i),
    .settle_vec_i(settle_vec_i),
    .sel_code_o  (sel_code_o),
    .sel_online_o(sel_online),
    .sel_loaded_o(sel_loaded),
    .sel_ready_o (sel_ready_o),
    .sel_settle_o(sel_settle_o)
  );

  tmotion_delay_cnt #(
    .PRESET_W(PRESET_W)
  ) delay_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (ctr_clear),
    .load_i     (delay_load_o),
    .count_en_i (count_en),
    .tick_i     (tick_i),
    .preset_i   (preset_i),
    .last_tick_o(last_tick)
  );

  tmotion_ctrl #(
    .LOAD_CYC(LOAD_CYC)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_set_i (drive_set_i),
    .stop_req_i  (stop_req_i),
    .sel_online_i(sel_online),
    .sel_loaded_i(sel_loaded),
    .cmd_write_i (cmd_write_i),
    .cmd_rewind_i(cmd_rewind_i),
    .last_tick_i (last_tick),
    .stop_o      (stop_o),
    .start_pls_o (start_pls_o),
    .delay_load_o(delay_load_o),
    .accel_o     (accel_o),
    .reading_o   (reading_o),
    .count_en_o  (count_en),
    .ctr_clear_o (ctr_clear),
    .hold_o      (hold),
    .mode_o      (mode_o)
  );

  AST_LAST_TICK_IN_ACCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_tick |=> reading_o || stop_o); // R5

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_o && drive_set_i && !delay_load_o |=> !start_pls_o); // R9

endmodule

// File: tb/tmotion_seq_tb_top.sv
module tmotion_seq_tb_top;

  localparam int PW = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] unit_sel = '0;
  logic [7:0] online_vec = '0, medium_vec = '0, ready_vec = '0, settle_vec = '0;
  logic       drive_set = 1'b0, stop_req = 1'b0, cmd_write = 1'b0, cmd_rewind = 1'b0;
  logic       tick = 1'b0;
  logic [PW-1:0] preset = '0;

  logic [2:0] sel_code;
  logic       sel_ready, sel_settle, stop_l, start_pls, delay_load, accel, reading;
  logic [1:0] mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  tmotion_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .unit_sel_i(unit_sel),
    .online_vec_i(online_vec), .medium_vec_i(medium_vec),
    .ready_vec_i(ready_vec), .settle_vec_i(settle_vec),
    .drive_set_i(drive_set), .stop_req_i(stop_req),
    .cmd_write_i(cmd_write), .cmd_rewind_i(cmd_rewind),
    .tick_i(tick), .preset_i(preset),
    .sel_code_o(sel_code), .sel_ready_o(sel_ready), .sel_settle_o(sel_settle),
    .stop_o(stop_l), .start_pls_o(start_pls), .delay_load_o(delay_load),
    .accel_o(accel), .reading_o(reading), .mode_o(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tick generator: one tick every tick_div cycles, off when 0.
  int tick_div = 0;
  int tick_ph = 0;
  always @(negedge clk) begin
    if (tick_div == 0) begin
      tick <= 1'b0; tick_ph <= 0;
    end else if (tick_ph >= tick_div - 1) begin
      tick <= 1'b1; tick_ph <= 0;
    end else begin
      tick <= 1'b0; tick_ph <= tick_ph + 1;
    end
  end

  // Scoreboard: expected delay lengths, compared when reading rises.
  int exp_q[$];
  int tick_seen = 0;
  logic read_prev = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      tick_seen = 0; read_prev = 1'b0;
    end else begin
      if (start_pls) tick_seen = 0;
      else if (accel && !delay_load && tick) tick_seen++;
      if (reading && !read_prev) begin
        if (exp_q.size() == 0) chk("R5 unexpected reading", 1, 0);
        else chk("R5 delay ticks", tick_seen, exp_q.pop_front());
      end
      read_prev = reading;
    end
  end

  task automatic pulse_start(input logic [PW-1:0] pre, input logic wr, input logic rw,
                             input bit expect_delay);
    @(negedge clk);
    preset = pre; cmd_write = wr; cmd_rewind = rw; drive_set = 1'b1;
    if (expect_delay) exp_q.push_back((1 << PW) - int'(pre));
    @(negedge clk);
    drive_set = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic wait_reading(input int max_cyc);
    for (int i = 0; i < max_cyc && !reading; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stop", stop_l, 1);
    chk("R1 start", start_pls, 0);
    chk("R1 load", delay_load, 0);
    chk("R1 accel", accel, 0);
    chk("R1 reading", reading, 0);
    chk("R1 mode", mode, 0);
    chk("R1 sel", sel_code, 0);
    rst_n = 1'b1;

    online_vec = 8'b1011_1111;  // unit 6 off-line
    medium_vec = 8'b1111_0111;  // unit 3 without tape
    ready_vec  = 8'b0010_0000;  // only unit 5 ready
    settle_vec = 8'b0100_0100;  // units 2 and 6 settling

    // R3 selection and status mux
    @(negedge clk); unit_sel = 3'd5;
    @(negedge clk);
    chk("R3 sel code", sel_code, 5);
    chk("R3 ready unit5", sel_ready, 1);
    chk("R3 settle unit5", sel_settle, 0);
    unit_sel = 3'd2;
    @(negedge clk);
    chk("R3 settle unit2", sel_settle, 1);
    chk("R3 ready unit2", sel_ready, 0);
    unit_sel = 3'd6;
    @(negedge clk);
    chk("R3 offline unit hides settle", sel_settle, 0);

    // R6 unqualified starts
    pulse_start(14'd100, 1'b0, 1'b0, 0);
    chk("R6 offline no start", start_pls, 0);
    chk("R6 offline stop held", stop_l, 1);
    unit_sel = 3'd3;
    @(negedge clk);
    pulse_start(14'd100, 1'b0, 1'b0, 0);
    chk("R6 no tape no start", start_pls, 0);
    @(negedge clk);
    chk("R6 no tape stop held", stop_l, 1);

    // R2 R4 R5 short delay, one tick per cycle
    unit_sel = 3'd5; tick_div = 1;
    @(negedge clk);
    pulse_start(14'd16380, 1'b0, 1'b0, 1);
    chk("R2 start pulse", start_pls, 1);
    chk("R2 load", delay_load, 1);
    chk("R2 stop released", stop_l, 0);
    chk("R2 accel", accel, 1);
    chk("R10 move mode", mode, 1);
    @(negedge clk);
    chk("R2 pulse one cycle", start_pls, 0);
    chk("R2 load second cycle", delay_load, 1);
    @(negedge clk);
    chk("R2 load ends", delay_load, 0);
    chk("R4 counting accel", accel, 1);
    wait_reading(100);
    chk("R5 reading", reading, 1);
    chk("R5 accel off", accel, 0);
    unit_sel = 3'd2; // R7 change ignored while moving
    repeat (20) @(negedge clk);
    chk("R5 reading held", reading, 1);
    chk("R7 sel held", sel_code, 5);
    do_stop();
    chk("R8 stop", stop_l, 1);
    chk("R8 reading off", reading, 0);
    @(negedge clk);
    chk("R3 sel follows when idle", sel_code, 2);
    unit_sel = 3'd5;
    @(negedge clk);

    // R4 R9 mid preset, one tick every third cycle
    tick_div = 3;
    pulse_start(14'd16000, 1'b0, 1'b0, 1);
    repeat (30) @(negedge clk);
    drive_set = 1'b1; preset = 14'd16383;
    @(negedge clk); drive_set = 1'b0;
    @(negedge clk);
    chk("R9 no restart while busy", start_pls, 0);
    chk("R9 still accelerating", accel, 1);
    wait_reading(2000);
    chk("R5 reading after 384", reading, 1);
    do_stop();

    // R8 stop mid count with drive_set together, then fresh start
    tick_div = 1;
    pulse_start(14'd100, 1'b0, 1'b0, 0);
    repeat (20) @(negedge clk);
    stop_req = 1'b1; drive_set = 1'b1;
    @(negedge clk); stop_req = 1'b0; drive_set = 1'b0;
    chk("R8 stop mid count", stop_l, 1);
    chk("R8 stop beats drive_set", start_pls, 0);
    chk("R8 accel off", accel, 0);
    repeat (5) @(negedge clk);
    chk("R8 stays stopped", stop_l, 1);
    pulse_start(14'd16383, 1'b0, 1'b0, 1);
    wait_reading(50);
    chk("R8 restart reaches reading", reading, 1);
    do_stop();

    // R4 R5 maximum delay
    pulse_start(14'd0, 1'b0, 1'b0, 1);
    wait_reading(17000);
    chk("R5 max delay reading", reading, 1);
    do_stop();

    // R10 write mode
    pulse_start(14'd16370, 1'b1, 1'b0, 1);
    chk("R10 write mode", mode, 2);
    wait_reading(100);
    chk("R5 write reading", reading, 1);
    do_stop();

    // R10 rewind with write
    pulse_start(14'd10, 1'b1, 1'b1, 0);
    chk("R10 rewind mode", mode, 3);
    chk("R10 rewind start pulse", start_pls, 1);
    chk("R10 rewind no accel", accel, 0);
    @(negedge clk);
    chk("R10 rewind still loading", stop_l, 0);
    @(negedge clk);
    chk("R10 rewind back to stop", stop_l, 1);
    chk("R10 rewind no reading", reading, 0);
    repeat (10) @(negedge clk);
    chk("R10 rewind stays stopped", accel, 0);

    // R10 rewind alone
    pulse_start(14'd10, 1'b0, 1'b1, 0);
    chk("R10 rewind only mode", mode, 3);
    repeat (3) @(negedge clk);
    chk("R10 rewind only stop", stop_l, 1);

    chk("R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule